// File: doc/BRIEF.md
# Scan Chain Transition Cost Accumulator

This block watches the contents of an m-bit scan register once per clock and turns the switching of that register into a weighted cost, used as a stand-in for test-mode power. Each accepted sample is compared bit by bit with the sample accepted before it. A latch that keeps its value costs 2 units and a latch that flips costs 6 units. The sum over all latches is the cost of that cycle.

A test session is opened with a start pulse and closed with a clear pulse. Inside a session, every sample that comes with the valid strobe is costed and added to a running total, and a cycle counter advances by one. Software reads the total and the count and divides one by the other to obtain the average cost per cycle. The total is sized so that it cannot wrap before the counter fills. A sample that arrives when the counter is already full sets a sticky overflow flag and freezes the total and the count.

Top module: `scan_cost_meter`

## Requirements
- R1: While `rst` is high, and after it is released, `cycle_cost`, `cost_total`, `cycle_count`, `cost_valid` and `overflow` are all zero and no session is open.
- R2: For an accepted sample with t latches that differ from the previous accepted vector, `cycle_cost` becomes 2*CHAIN_W + 4*t (2 per held latch, 6 per flipped latch) on the clock edge that accepts it.
- R3: The first sample accepted after a start pulse is compared against an all-zero vector.
- R4: Each accepted sample adds its cost to `cost_total` and increments `cycle_count` by one, both on the edge that accepts it.
- R5: A sample is accepted only when `sample_valid` is high, a session is open, and neither `sess_start` nor `sess_clear` is high; otherwise `cost_total`, `cycle_count`, `cycle_cost` and the stored previous vector keep their values.
- R6: `sess_start` zeroes the total, the count, the cost, the overflow flag and the previous vector and opens a session; `sess_clear` does the same zeroing and closes the session; when both are high, the clear wins and the session is closed.
- R7: An accepted sample that arrives when `cycle_count` is all ones sets `overflow`, which then stays high until a start, a clear or reset; `cost_total` and `cycle_count` are held from that point.
- R8: `cost_valid` is high for exactly the cycle after each accepted sample and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_start | input | 1 | Zero the results and open a session |
| sess_clear | input | 1 | Zero the results and close the session |
| sample_valid | input | 1 | Marks `scan_vec` as a sample to cost |
| scan_vec | input | CHAIN_W | Current scan register contents |
| cycle_cost | output | COST_W | Cost of the last accepted sample |
| cost_total | output | TOTAL_W | Sum of costs in the session |
| cycle_count | output | CNT_W | Number of accepted samples in the session |
| cost_valid | output | 1 | One-cycle pulse after an accepted sample |
| overflow | output | 1 | Sticky: the cycle counter would have wrapped |

## Verification
The two functions that can meet in one cycle are the zeroing done by start or clear and the accumulation of a valid sample; the bench raises `sample_valid` together with `sess_start`, with `sess_clear` and with both, and expects the zeroed state with the sample discarded and the next sample compared against zeros. A second collision is the full counter meeting a valid sample: after 1023 accepted samples one more is offered, and the bench expects the overflow flag with total and count frozen, then a start in the following cycle that must clear the flag. Random runs mix these collisions with idle cycles and are judged against a bench model of the cost rule.

// File: rtl/scan_cost_pkg.sv
package scan_cost_pkg;
  localparam int HOLD_COST = 2;
  localparam int FLIP_COST = 6;
  localparam int FLIP_EXTRA = FLIP_COST - HOLD_COST;
endpackage

// File: rtl/sc_toggle_cost.sv
module sc_toggle_cost #(
  parameter int CHAIN_W = 8,
  parameter int COST_W  = 6
) (
  input  logic [CHAIN_W-1:0] cur_vec,
  input  logic [CHAIN_W-1:0] prev_vec,
  output logic [COST_W-1:0]  cost
);
  import scan_cost_pkg::*;
  localparam int POP_W = $clog2(CHAIN_W + 1);

  logic [CHAIN_W-1:0] flip;
  logic [POP_W-1:0]   flips;

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_bit
    assign flip[i] = cur_vec[i] ^ prev_vec[i];
  end

  always_comb begin
    flips = '0;
    for (int i = 0; i < CHAIN_W; i++) begin
      flips = flips + POP_W'(flip[i]);
    end
  end

  assign cost = COST_W'(HOLD_COST * CHAIN_W) + COST_W'(FLIP_EXTRA) * COST_W'(flips);

  always_comb begin
    assert (cost >= COST_W'(HOLD_COST * CHAIN_W) && cost <= COST_W'(FLIP_COST * CHAIN_W))
      else $error("p_cost_bounds_r2: cost out of range");
  end
endmodule

// File: rtl/sc_session.sv
module sc_session #(
  parameter int CHAIN_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sess_start,
  input  logic               sess_clear,
  input  logic               sample_valid,
  input  logic [CHAIN_W-1:0] scan_vec,
  output logic               accept,
  output logic               zero_req,
  output logic [CHAIN_W-1:0] prev_vec
);
  logic active_q;

  assign zero_req = sess_start | sess_clear;
  assign accept   = sample_valid & active_q & ~zero_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      prev_vec <= '0;
    end else if (zero_req) begin
      active_q <= ~sess_clear;
      prev_vec <= '0;
    end else if (accept) begin
      prev_vec <= scan_vec;
    end
  end

  p_prev_zero_r3: assert property (@(posedge clk) disable iff (rst)
    zero_req |=> (prev_vec == '0));

  p_prev_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!accept && !zero_req) |=> $stable(prev_vec));

  p_clear_closes_r6: assert property (@(posedge clk) disable iff (rst)
    sess_clear |=> !accept);
endmodule

// File: rtl/sc_accum.sv
module sc_accum #(
  parameter int COST_W  = 6,
  parameter int CNT_W   = 10,
  parameter int TOTAL_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               zero_req,
  input  logic [COST_W-1:0]  cost_in,
  output logic [COST_W-1:0]  cycle_cost,
  output logic [TOTAL_W-1:0] cost_total,
  output logic [CNT_W-1:0]   cycle_count,
  output logic               cost_valid,
  output logic               overflow
);
  logic cnt_full;
  assign cnt_full = &cycle_count;

  always_ff @(posedge clk) begin
    if (rst || zero_req) begin
      cycle_cost  <= '0;
      cost_total  <= '0;
      cycle_count <= '0;
      cost_valid  <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      cost_valid <= accept;
      if (accept) begin
        cycle_cost <= cost_in;
        if (cnt_full) begin
          overflow <= 1'b1;
        end else begin
          cost_total  <= cost_total + TOTAL_W'(cost_in);
          cycle_count <= cycle_count + 1'b1;
        end
      end
    end
  end

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && !zero_req && !cnt_full) |=> (cycle_count == $past(cycle_count) + 1'b1));

  p_total_step_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && !zero_req && !cnt_full) |=> (cost_total == $past(cost_total) + TOTAL_W'($past(cost_in))));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!accept && !zero_req) |=> ($stable(cost_total) && $stable(cycle_count) && $stable(cycle_cost)));

  p_zeroing_r6: assert property (@(posedge clk) disable iff (rst)
    zero_req |=> (cost_total == '0 && cycle_count == '0 && !overflow));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (overflow && !zero_req) |=> (overflow && $stable(cost_total) && $stable(cycle_count)));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && !zero_req) |=> cost_valid);
endmodule

// File: rtl/scan_cost_meter.sv
module scan_cost_meter #(
  parameter  int CHAIN_W = 8,
  parameter  int CNT_W   = 10,
  localparam int COST_W  = $clog2(scan_cost_pkg::FLIP_COST * CHAIN_W + 1),
  localparam int TOTAL_W = CNT_W + COST_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sess_start,
  input  logic               sess_clear,
  input  logic               sample_valid,
  input  logic [CHAIN_W-1:0] scan_vec,
  output logic [COST_W-1:0]  cycle_cost,
  output logic [TOTAL_W-1:0] cost_total,
  output logic [CNT_W-1:0]   cycle_count,
  output logic               cost_valid,
  output logic               overflow
);
  logic               accept;
  logic               zero_req;
  logic [CHAIN_W-1:0] prev_vec;
  logic [COST_W-1:0]  cost_now;

  sc_session #(.CHAIN_W(CHAIN_W)) u_session (
    .clk          (clk),
    .rst          (rst),
    .sess_start   (sess_start),
    .sess_clear   (sess_clear),
    .sample_valid (sample_valid),
    .scan_vec     (scan_vec),
    .accept       (accept),
    .zero_req     (zero_req),
    .prev_vec     (prev_vec)
  );

  sc_toggle_cost #(.CHAIN_W(CHAIN_W), .COST_W(COST_W)) u_cost (
    .cur_vec  (scan_vec),
    .prev_vec (prev_vec),
    .cost     (cost_now)
  );

  sc_accum #(.COST_W(COST_W), .CNT_W(CNT_W), .TOTAL_W(TOTAL_W)) u_accum (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .zero_req    (zero_req),
    .cost_in     (cost_now),
    .cycle_cost  (cycle_cost),
    .cost_total  (cost_total),
    .cycle_count (cycle_count),
    .cost_valid  (cost_valid),
    .overflow    (overflow)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cost_total == '0 && cycle_count == '0 && !cost_valid && !overflow));
endmodule

// File: tb/scan_cost_meter_bench.sv
module scan_cost_meter_bench;
  localparam int CHAIN_W = 8;
  localparam int CNT_W   = 10;
  localparam int COST_W  = $clog2(6 * CHAIN_W + 1);
  localparam int TOTAL_W = CNT_W + COST_W;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sess_start = 1'b0, sess_clear = 1'b0, sample_valid = 1'b0;
  logic [CHAIN_W-1:0] scan_vec = '0;
  logic [COST_W-1:0]  cycle_cost;
  logic [TOTAL_W-1:0] cost_total;
  logic [CNT_W-1:0]   cycle_count;
  logic cost_valid, overflow;

  int n_checks = 0;
  int n_fails  = 0;

  // bench model
  bit              m_active = 0;
  logic [CHAIN_W-1:0] m_prev = '0;
  int              m_cost = 0, m_total = 0, m_count = 0;
  bit              m_cv = 0, m_ovf = 0;

  always #2 clk = ~clk;

  scan_cost_meter #(.CHAIN_W(CHAIN_W), .CNT_W(CNT_W)) u_scan_cost_meter (
    .clk(clk), .rst(rst), .sess_start(sess_start), .sess_clear(sess_clear),
    .sample_valid(sample_valid), .scan_vec(scan_vec),
    .cycle_cost(cycle_cost), .cost_total(cost_total), .cycle_count(cycle_count),
    .cost_valid(cost_valid), .overflow(overflow)
  );

  function automatic int expect_cost(logic [CHAIN_W-1:0] a, logic [CHAIN_W-1:0] b);
    int c = 0;
    for (int i = 0; i < CHAIN_W; i++) c += (a[i] == b[i]) ? 2 : 6;
    return c;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, "cycle_cost", int'(cycle_cost), m_cost);
    check(req, "cost_total", int'(cost_total), m_total);
    check(req, "cycle_count", int'(cycle_count), m_count);
    check(req, "cost_valid", int'(cost_valid), int'(m_cv));
    check(req, "overflow", int'(overflow), int'(m_ovf));
  endtask

  // drive at negedge, model the edge, sample one time unit after it
  task automatic step(bit st, bit cl, bit v, logic [CHAIN_W-1:0] vec, string req);
    bit acc;
    @(negedge clk);
    sess_start = st; sess_clear = cl; sample_valid = v; scan_vec = vec;
    acc = v && m_active && !st && !cl;
    if (st || cl) begin
      m_active = !cl; m_prev = '0; m_cost = 0; m_total = 0; m_count = 0;
      m_cv = 0; m_ovf = 0;
    end else begin
      m_cv = acc;
      if (acc) begin
        m_cost = expect_cost(vec, m_prev);
        m_prev = vec;
        if (m_count == CNT_MAX) m_ovf = 1;
        else begin m_total += m_cost; m_count++; end
      end
    end
    @(posedge clk);
    #1;
    check_all(req);
  endtask

  initial begin
    #200000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check_all("R1");

    // valid without a session is ignored
    step(0, 0, 1, 8'hFF, "R5");
    // open session with a sample in the same cycle: sample discarded
    step(1, 0, 1, 8'hA5, "R6");
    // first sample vs zeros: all flip -> 48
    step(0, 0, 1, 8'hFF, "R3");
    // same vector again: all held -> 16
    step(0, 0, 1, 8'hFF, "R2");
    // two flips -> 24
    step(0, 0, 1, 8'hFC, "R2");
    // idle cycles change nothing
    step(0, 0, 0, 8'h00, "R5");
    step(0, 0, 0, 8'h55, "R8");
    step(0, 0, 1, 8'h0C, "R4");
    // clear and start together: clear wins, session closed
    step(1, 1, 1, 8'hFF, "R6");
    step(0, 0, 1, 8'hFF, "R6");
    // restart, prev is zero again
    step(1, 0, 0, 8'h00, "R6");
    step(0, 0, 1, 8'h01, "R3");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 3, (r >= 3 && r < 5), ($urandom_range(0, 3) != 0),
           CHAIN_W'($urandom), "R4");
    end

    // fill the counter, then overflow
    step(1, 0, 0, 8'h00, "R6");
    for (int i = 0; i < CNT_MAX; i++) step(0, 0, 1, 8'h00, "R4");
    check("R7", "count at full", int'(cycle_count), CNT_MAX);
    step(0, 0, 1, 8'hFF, "R7");
    check("R7", "overflow set", int'(overflow), 1);
    step(0, 0, 1, 8'h00, "R7");
    step(0, 0, 0, 8'h00, "R7");
    // start in the cycle after overflow clears the flag
    step(1, 0, 1, 8'h00, "R7");
    check("R7", "overflow cleared", int'(overflow), 0);
    step(0, 0, 1, 8'h81, "R8");
    step(0, 0, 0, 8'h81, "R8");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule